// File: doc/BRIEF.md
# Render Scroll Timing Strobe Generator

This block keeps the beam position of a tile-based video processor: a dot counter within the scanline and a scanline counter within the frame. From that position it decodes four single-cycle strobes that tell a separate scroll-address unit when to update. The strobes are: step the tile column, step the row, reload the horizontal part from the latched scroll, and reload the vertical part from the latched scroll.

A per-dot enable paces the block. The counters move only on enabled cycles, and each strobe is valid in the same cycle as the dot it belongs to. Strobes appear only while rendering is switched on. Two bits of the 8-bit mask input control this: bit 3 is the background enable and bit 4 is the sprite enable. Either one is enough.

A small state machine tracks which kind of line the beam is on:
- `LK_VISIBLE` covers lines 0 to 239.
- `LK_IDLE` covers lines 240 to 260.
- `LK_PRE` covers line 261, the pre-render line.

It moves on the last dot of a line, through three named transitions:
- `T_VIS_TO_IDLE` at the end of line 239.
- `T_IDLE_TO_PRE` at the end of line 260.
- `T_PRE_TO_VIS` at the end of line 261.

Top module: `render_strobe_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `dot_o` and `line_o` read 0 and all four strobes are low until the first enabled cycle.
- R2: On each enabled cycle the dot advances by one. After dot 340 it returns to 0 and the line advances. After line 261 the line returns to 0.
- R3: When `dot_en` is low, dot and line hold their values and all strobes are low.
- R4: Strobes are produced only when `mask[3]` or `mask[4]` is 1. With both bits 0, all strobes are low.
- R5: Strobes are produced only on lines 0 to 239 and on line 261. Lines 240 to 260 are silent.
- R6: `inc_x_o` fires on dots 8, 16, …, 256 (nonzero multiples of 8) and on dots 328 and 336. It does not fire on dot 0.
- R7: `inc_y_o` fires on dot 256, in the same cycle as `inc_x_o`.
- R8: `copy_h_o` fires on dot 257.
- R9: `copy_v_o` fires on each dot from 280 to 304 inclusive, and only on line 261.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Per-dot advance enable |
| mask | input | 8 | Rendering mask; bit 3 enables background, bit 4 enables sprites |
| dot_o | output | 9 | Current dot in the line (0–340) |
| line_o | output | 9 | Current line in the frame (0–261) |
| inc_x_o | output | 1 | Step tile column |
| inc_y_o | output | 1 | Step row |
| copy_h_o | output | 1 | Reload horizontal scroll |
| copy_v_o | output | 1 | Reload vertical scroll |

## Verification
The strobes are combinational from the current position, `dot_en` and `mask`, so they are due in the same cycle the inputs are applied. The bench drives each cycle's inputs on the falling edge and compares all outputs a short time later, before the rising edge. The position outputs change one rising edge after an enabled cycle. The bench therefore advances its own model of dot and line only after that cycle's comparison, and the next falling-edge comparison sees the new position.

// File: rtl/scroll_timing_pkg.sv
package scroll_timing_pkg;

    typedef enum logic [1:0] {
        LK_VISIBLE = 2'd0,
        LK_IDLE    = 2'd1,
        LK_PRE     = 2'd2
    } line_kind_e;

    typedef struct packed {
        logic inc_x;
        logic inc_y;
        logic copy_h;
        logic copy_v;
    } scroll_strobe_t;

endpackage

// File: rtl/rts_beam_counter.sv
module rts_beam_counter #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    localparam int DW = $clog2(DOTS_PER_LINE),
    localparam int LW = $clog2(LINES_PER_FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [DW-1:0] dot,
    output logic [LW-1:0] line,
    output logic          line_end
);
    localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS_PER_LINE - 1);
    localparam logic [LW-1:0] LAST_LINE = LW'(LINES_PER_FRAME - 1);

    assign line_end = adv && (dot == LAST_DOT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot  <= '0;
            line <= '0;
        end else if (adv) begin
            if (dot == LAST_DOT) begin
                dot  <= '0;
                line <= (line == LAST_LINE) ? '0 : line + 1'b1;
            end else begin
                dot <= dot + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rts_line_fsm.sv
module rts_line_fsm
    import scroll_timing_pkg::*;
#(
    parameter int LINES_PER_FRAME = 262,
    parameter int VISIBLE_LINES   = 240,
    localparam int LW = $clog2(LINES_PER_FRAME)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_end,
    input  logic [LW-1:0] line,
    output line_kind_e    kind,
    output logic          render_line,
    output logic          pre_line
);
    localparam logic [LW-1:0] LAST_VIS  = LW'(VISIBLE_LINES - 1);
    localparam logic [LW-1:0] LAST_IDLE = LW'(LINES_PER_FRAME - 2);

    line_kind_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_VISIBLE: if (line_end && line == LAST_VIS)  state_d = LK_IDLE;    // T_VIS_TO_IDLE
            LK_IDLE:    if (line_end && line == LAST_IDLE) state_d = LK_PRE;     // T_IDLE_TO_PRE
            LK_PRE:     if (line_end)                      state_d = LK_VISIBLE; // T_PRE_TO_VIS
            default:                                       state_d = LK_VISIBLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_VISIBLE;
        else        state_q <= state_d;
    end

    always_comb begin
        kind        = state_q;
        render_line = 1'b0;
        pre_line    = 1'b0;
        unique case (state_q)
            LK_VISIBLE: render_line = 1'b1;
            LK_IDLE:    render_line = 1'b0;
            LK_PRE: begin
                render_line = 1'b1;
                pre_line    = 1'b1;
            end
            default:    render_line = 1'b0;
        endcase
    end
endmodule

// File: rtl/rts_strobe_decode.sv
module rts_strobe_decode
    import scroll_timing_pkg::*;
#(
    parameter int DOTS_PER_LINE = 341,
    parameter int TILE_DOTS     = 8,
    parameter int FETCH_END     = 256,
    parameter int PREFETCH_A    = 328,
    parameter int PREFETCH_B    = 336,
    parameter int VCOPY_FIRST   = 280,
    parameter int VCOPY_LAST    = 304,
    localparam int DW = $clog2(DOTS_PER_LINE)
) (
    input  logic [DW-1:0] dot,
    input  logic          adv,
    input  logic          render_on,
    input  logic          render_line,
    input  logic          pre_line,
    output scroll_strobe_t strobe
);
    localparam logic [DW-1:0] TILE_MASK = DW'(TILE_DOTS - 1);
    localparam logic [DW-1:0] D_FETCH   = DW'(FETCH_END);
    localparam logic [DW-1:0] D_HCOPY   = DW'(FETCH_END + 1);
    localparam logic [DW-1:0] D_PF_A    = DW'(PREFETCH_A);
    localparam logic [DW-1:0] D_PF_B    = DW'(PREFETCH_B);
    localparam logic [DW-1:0] D_VC_LO   = DW'(VCOPY_FIRST);
    localparam logic [DW-1:0] D_VC_HI   = DW'(VCOPY_LAST);

    logic gate, tile_edge, prefetch, in_vwin;

    always_comb begin
        gate      = adv && render_on && render_line;
        tile_edge = ((dot & TILE_MASK) == '0) && (dot != '0) && (dot <= D_FETCH);
        prefetch  = (dot == D_PF_A) || (dot == D_PF_B);
        in_vwin   = (dot >= D_VC_LO) && (dot <= D_VC_HI);

        strobe.inc_x  = gate && (tile_edge || prefetch);
        strobe.inc_y  = gate && (dot == D_FETCH);
        strobe.copy_h = gate && (dot == D_HCOPY);
        strobe.copy_v = gate && pre_line && in_vwin;
    end
endmodule

// File: rtl/render_strobe_gen.sv
module render_strobe_gen
    import scroll_timing_pkg::*;
#(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VISIBLE_LINES   = 240,
    parameter int MASK_W          = 8,
    parameter int BG_EN_BIT       = 3,
    parameter int SPR_EN_BIT      = 4,
    localparam int DW = $clog2(DOTS_PER_LINE),
    localparam int LW = $clog2(LINES_PER_FRAME)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic [MASK_W-1:0] mask,
    output logic [DW-1:0]     dot_o,
    output logic [LW-1:0]     line_o,
    output logic              inc_x_o,
    output logic              inc_y_o,
    output logic              copy_h_o,
    output logic              copy_v_o
);
    localparam logic [MASK_W-1:0] RENDER_BITS =
        (MASK_W'(1) << BG_EN_BIT) | (MASK_W'(1) << SPR_EN_BIT);

    logic           line_end, render_line, pre_line, render_on;
    logic           unused_mask;
    line_kind_e     kind;
    scroll_strobe_t strobe;

    assign render_on   = |(mask & RENDER_BITS);
    assign unused_mask = ^(mask & ~RENDER_BITS) ^ (kind == LK_IDLE);

    rts_beam_counter #(
        .DOTS_PER_LINE  (DOTS_PER_LINE),
        .LINES_PER_FRAME(LINES_PER_FRAME)
    ) u_beam (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (dot_en),
        .dot     (dot_o),
        .line    (line_o),
        .line_end(line_end)
    );

    rts_line_fsm #(
        .LINES_PER_FRAME(LINES_PER_FRAME),
        .VISIBLE_LINES  (VISIBLE_LINES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .line       (line_o),
        .kind       (kind),
        .render_line(render_line),
        .pre_line   (pre_line)
    );

    rts_strobe_decode #(
        .DOTS_PER_LINE(DOTS_PER_LINE)
    ) u_dec (
        .dot        (dot_o),
        .adv        (dot_en),
        .render_on  (render_on),
        .render_line(render_line),
        .pre_line   (pre_line),
        .strobe     (strobe)
    );

    assign inc_x_o  = strobe.inc_x;
    assign inc_y_o  = strobe.inc_y;
    assign copy_h_o = strobe.copy_h;
    assign copy_v_o = strobe.copy_v;
endmodule

// File: rtl/render_strobe_gen_checker.sv
module render_strobe_gen_checker #(
    parameter int DOTS_PER_LINE   = 341,
    parameter int LINES_PER_FRAME = 262,
    parameter int VISIBLE_LINES   = 240,
    parameter int MASK_W          = 8,
    localparam int DW = $clog2(DOTS_PER_LINE),
    localparam int LW = $clog2(LINES_PER_FRAME)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dot_en,
    input logic [MASK_W-1:0] mask,
    input logic [DW-1:0]     dot_o,
    input logic [LW-1:0]     line_o,
    input logic              inc_x_o,
    input logic              inc_y_o,
    input logic              copy_h_o,
    input logic              copy_v_o
);
    localparam logic [DW-1:0] LAST_DOT  = DW'(DOTS_PER_LINE - 1);
    localparam logic [LW-1:0] PRE_LINE  = LW'(LINES_PER_FRAME - 1);
    localparam logic [LW-1:0] FIRST_IDL = LW'(VISIBLE_LINES);

    logic any_strobe;
    assign any_strobe = inc_x_o | inc_y_o | copy_h_o | copy_v_o;

    a_r2_dot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_en && dot_o == LAST_DOT) |=> (dot_o == '0));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |=> ($stable(dot_o) && $stable(line_o)));

    a_r3_quiet_when_paused: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_en |-> !any_strobe);

    a_r4_quiet_no_render: assert property (@(posedge clk) disable iff (!rst_n)
        (mask[4:3] == 2'b00) |-> !any_strobe);

    a_r5_quiet_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o >= FIRST_IDL && line_o < PRE_LINE) |-> !any_strobe);

    a_r7_incy_with_incx: assert property (@(posedge clk) disable iff (!rst_n)
        inc_y_o |-> inc_x_o);

    a_r8_hcopy_after_incy: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_y_o && dot_en && $stable(mask)) |=> (dot_en -> copy_h_o));

    a_r9_vcopy_pre_only: assert property (@(posedge clk) disable iff (!rst_n)
        copy_v_o |-> (line_o == PRE_LINE && !inc_x_o && !copy_h_o));

    a_r9_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({copy_h_o, copy_v_o, inc_y_o}));
endmodule

bind render_strobe_gen render_strobe_gen_checker #(
    .DOTS_PER_LINE  (DOTS_PER_LINE),
    .LINES_PER_FRAME(LINES_PER_FRAME),
    .VISIBLE_LINES  (VISIBLE_LINES),
    .MASK_W         (MASK_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .dot_en  (dot_en),
    .mask    (mask),
    .dot_o   (dot_o),
    .line_o  (line_o),
    .inc_x_o (inc_x_o),
    .inc_y_o (inc_y_o),
    .copy_h_o(copy_h_o),
    .copy_v_o(copy_v_o)
);

// File: tb/render_strobe_gen_test.sv
module render_strobe_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dot_en = 1'b0;
    logic [7:0] mask = 8'h00;
    logic [8:0] dot_o, line_o;
    logic       inc_x_o, inc_y_o, copy_h_o, copy_v_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;
    int m_dot = 0;
    int m_line = 0;

    always #10 clk = ~clk;

    render_strobe_gen uut (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .mask(mask),
        .dot_o(dot_o), .line_o(line_o), .inc_x_o(inc_x_o),
        .inc_y_o(inc_y_o), .copy_h_o(copy_h_o), .copy_v_o(copy_v_o)
    );

    // Expected strobes {inc_x, inc_y, copy_h, copy_v} from the requirements
    function automatic logic [3:0] exp_strobes(int d, int l, bit en, logic [7:0] m);
        bit gate;
        logic [3:0] r;
        gate = en && (m[3] || m[4]) && (l <= 239 || l == 261);
        r[3] = gate && (((d % 8 == 0) && d != 0 && d <= 256) || d == 328 || d == 336);
        r[2] = gate && (d == 256);
        r[1] = gate && (d == 257);
        r[0] = gate && (l == 261) && (d >= 280) && (d <= 304);
        return r;
    endfunction

    task automatic cmp(string tag, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s dot=%0d line=%0d: actual %0d expected %0d",
                     tag, m_dot, m_line, act, exp);
        end
    endtask

    task automatic check_all(string pos_tag);
        logic [3:0] e;
        e = exp_strobes(m_dot, m_line, dot_en, mask);
        cmp(pos_tag, int'(dot_o), m_dot);
        cmp(pos_tag, int'(line_o), m_line);
        cmp("R6 inc_x", int'(inc_x_o), int'(e[3]));
        cmp("R7 inc_y", int'(inc_y_o), int'(e[2]));
        cmp("R8 copy_h", int'(copy_h_o), int'(e[1]));
        cmp("R9 copy_v", int'(copy_v_o), int'(e[0]));
    endtask

    task automatic model_step();
        if (dot_en) begin
            if (m_dot == 340) begin
                m_dot = 0;
                m_line = (m_line == 261) ? 0 : m_line + 1;
            end else begin
                m_dot++;
            end
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            mismatched++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cycles, 190000);
            summary();
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'h5C0_11E5);

        // R1: reset state, with inputs that would otherwise produce activity
        @(negedge clk);
        dot_en = 1'b1; mask = 8'h18;
        repeat (3) @(negedge clk);
        #2;
        cmp("R1 dot", int'(dot_o), 0);
        cmp("R1 line", int'(line_o), 0);
        cmp("R1 strobes", int'({inc_x_o, inc_y_o, copy_h_o, copy_v_o}), 0);
        @(negedge clk);
        dot_en = 1'b0;
        rst_n = 1'b1;
        #2;
        cmp("R1 post-reset dot", int'(dot_o), 0);
        cmp("R1 post-reset strobes", int'({inc_x_o, inc_y_o, copy_h_o, copy_v_o}), 0);

        // R3: paused cycles hold position and stay silent
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            dot_en = 1'b0; mask = 8'h18;
            #2;
            check_all("R3 hold");
            model_step();
        end

        // Directed segments then random stimulus across a whole frame
        for (int i = 0; i < 97000; i++) begin
            @(negedge clk);
            if (i < 400) begin
                dot_en = 1'b1; mask = 8'h08;            // R4 background only
            end else if (i < 800) begin
                dot_en = 1'b1; mask = 8'h10;            // R4 sprites only
            end else if (i < 1100) begin
                dot_en = 1'b1; mask = 8'hE7;            // R4 both enables clear
            end else begin
                logic [7:0] m;
                m = 8'($urandom);
                if (($urandom % 8) != 0) begin
                    if (!(m[3] || m[4])) m[3] = 1'b1;
                end else begin
                    m[4:3] = 2'b00;
                end
                mask = m;
                dot_en = (($urandom % 16) != 0);
            end
            #2;
            check_all((m_dot == 0) ? "R2 wrap position" : "R5 position");
            model_step();
        end

        done = 1;
        summary();
        $finish;
    end
endmodule